// File: doc/BRIEF.md
# Programmable Trigger Delay and Shaper

This block takes one asynchronous trigger input and turns each accepted rising edge into two clean output pulses, one for each of two detector branches (A and B). Each branch waits its own programmable delay and then drives a pulse whose length comes from a non-linear 4-bit width code. Short codes add a fixed base length, so small values still give pulses long enough for slow receivers. Long codes scale the length directly.

The block also counts accepted first-level triggers. When the count reaches a programmed threshold it raises a one-cycle second-level request and starts counting again from zero. All settings come from a single 32-bit settings word. The word is taken only when a trigger is accepted, so a pulse in flight is never changed by a new setting. The clock runs at 200 MHz, so one cycle is 5 ns and one 20 ns delay step is four cycles.

Top module: `trig_delay_shaper`

## Requirements
- R1: Reset is synchronous and active low. While `rst_n` is low at a rising clock edge, the next cycle has `out_a`, `out_b` and `l2_req` low, and the edge detector, both branches and the event counter are cleared.
- R2: `trig_in` passes through a two-stage synchroniser and then a rising-edge detector. With a delay field of 0, an accepted trigger drives the branch output high after the third rising clock edge at which `trig_in` is sampled high.
- R3: The branch-B delay is `cfg_word[16:12]` and the branch-A delay is `cfg_word[21:17]`. Each unit adds exactly 4 clock cycles (20 ns) to the rise time given in R2. The field range is 0 to 31.
- R4: The width code W is `cfg_word[31:28]`. The output stays high for 21+W cycles when W < 7 (105 ns + W·5 ns) and for W cycles otherwise. Both branches use the same width.
- R5: A trigger input that is held high produces exactly one accepted trigger. A new trigger needs the input to go low and then high again.
- R6: A rising edge that is detected while either branch is still delaying or still driving its pulse is ignored. It does not start a pulse and it does not advance the event counter.
- R7: The delay fields, the width code and the threshold are sampled in the cycle in which a trigger is accepted. Changing `cfg_word` afterwards does not alter the delay, width or count decision of that trigger.
- R8: The threshold N is `cfg_word[7:0]`. Each accepted trigger adds one to the event count. When the new count is greater than or equal to N, `l2_req` is high for one cycle (the cycle after the accept, the same cycle a delay-0 output would rise) and the count returns to zero. N = 0 never raises `l2_req` and holds the count at zero.
- R9: An edge that is detected in the first cycle after both branches have finished their pulses is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 200 MHz clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_in | input | 1 | Asynchronous trigger input |
| cfg_word | input | 32 | Settings word: delays, width code and second-level threshold |
| out_a | output | 1 | Delayed, shaped pulse for branch A |
| out_b | output | 1 | Delayed, shaped pulse for branch B |
| l2_req | output | 1 | One-cycle second-level request |

## Verification
The bench targets the width knee between codes 6 and 7, where a design that left out the base would emit 6-cycle pulses instead of 27, or one that applied the base to every code would stretch long pulses. It probes delay 0 against delay 31 and swaps the A and B fields, which would expose a design that adds a cycle to every delay, drops the zero case, or mixes up the two fields. It fires triggers into a busy block and into the exact cycle after the last pulse ends: the first catches a design that counts or restarts on ignored edges, and the second catches one that stays busy a cycle too long. It also changes the settings word in the middle of a pulse, lowers the threshold below the current count, and sets the threshold to zero. A design that read the settings live, or compared the count only for equality, would then produce shifted pulses or lose requests.

// File: rtl/trig_dly_pkg.sv
// Shared types and helpers for the trigger delay and shaper.
// Assumes: width codes are small unsigned values and the knee and base are
// positive.
package trig_dly_pkg;

    // Phases of one branch sequencer
    typedef enum logic [1:0] {
        BR_IDLE  = 2'd0,
        BR_DELAY = 2'd1,
        BR_PULSE = 2'd2
    } br_state_t;

    // Convert a width code to a pulse length in clock cycles (piecewise)
    function automatic int width_cycles(input int code, input int knee, input int base);
        if (code < knee)
            return base + code;
        else
            return code;
    endfunction

endpackage

// File: rtl/trig_edge_sync.sv
// Synchroniser plus rising-edge detector for the asynchronous trigger.
// Assumes: the trigger stays high for at least one clock period, so every
// edge it produces is seen at least once.
module trig_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);

    localparam int CHAIN_LEN = SYNC_STAGES + 1;

    logic [CHAIN_LEN-1:0] chain;

    // Shift the raw input through the synchroniser and keep one history stage
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain <= '0;
        else
            chain <= {chain[CHAIN_LEN-2:0], async_in};
    end

    // A rise is a synchronised high whose previous sample was low
    always_comb begin
        rise = chain[CHAIN_LEN-2] & ~chain[CHAIN_LEN-1];
    end

endmodule

// File: rtl/trig_branch.sv
// One output branch: counts down a programmable delay, then drives a pulse
// for a programmable number of cycles.
// Assumes: start arrives only while the branch is idle. The codes are taken
// in the start cycle and never read again during the pulse.
module trig_branch
    import trig_dly_pkg::*;
#(
    parameter int DLY_W     = 5,
    parameter int WCODE_W   = 4,
    parameter int TICKS     = 4,
    parameter int W_BASE    = 21,
    parameter int W_KNEE    = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [DLY_W-1:0]   dly_code,
    input  logic [WCODE_W-1:0] wid_code,
    output logic               pulse,
    output logic               active
);

    localparam int DLY_MAX  = ((1 << DLY_W) - 1) * TICKS;
    localparam int DCNT_W   = $clog2(DLY_MAX + 1);
    localparam int WID_MAX  = W_BASE + (1 << WCODE_W);
    localparam int WCNT_W   = $clog2(WID_MAX + 1);

    br_state_t          state;
    logic [DCNT_W-1:0]  dcnt;
    logic [WCNT_W-1:0]  wcnt;
    logic [WCNT_W-1:0]  wid_load;
    logic [DCNT_W-1:0]  dly_load;

    // Translate the codes into down-counter start values
    always_comb begin
        wid_load = WCNT_W'(width_cycles(int'(wid_code), W_KNEE, W_BASE) - 1);
        dly_load = DCNT_W'(int'(dly_code) * TICKS - 1);
    end

    // Sequence idle -> delay -> pulse -> idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= BR_IDLE;
            dcnt  <= '0;
            wcnt  <= '0;
        end else begin
            unique case (state)
                BR_IDLE: begin
                    if (start) begin
                        wcnt <= wid_load;
                        if (dly_code == '0) begin
                            state <= BR_PULSE;
                        end else begin
                            dcnt  <= dly_load;
                            state <= BR_DELAY;
                        end
                    end
                end
                BR_DELAY: begin
                    if (dcnt == '0)
                        state <= BR_PULSE;
                    else
                        dcnt <= dcnt - 1'b1;
                end
                BR_PULSE: begin
                    if (wcnt == '0)
                        state <= BR_IDLE;
                    else
                        wcnt <= wcnt - 1'b1;
                end
                default: state <= BR_IDLE;
            endcase
        end
    end

    // Decode the phase into the pulse and busy indications
    always_comb begin
        pulse  = (state == BR_PULSE);
        active = (state != BR_IDLE);
    end

endmodule

// File: rtl/l1_event_counter.sv
// Counts accepted first-level triggers and emits a one-cycle second-level
// request when the count reaches the threshold sampled with the trigger.
// Assumes: a threshold of zero disables the request entirely.
module l1_event_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic [CNT_W-1:0] thresh,
    output logic             req
);

    logic [CNT_W-1:0] count;
    logic [CNT_W:0]   next_count;

    // Widened next count so that the comparison cannot wrap
    always_comb begin
        next_count = {1'b0, count} + 1'b1;
    end

    // Advance on each accepted trigger, fire and clear at the threshold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            req   <= 1'b0;
        end else begin
            req <= 1'b0;
            if (hit) begin
                if (thresh == '0) begin
                    count <= '0;
                end else if (next_count >= {1'b0, thresh}) begin
                    count <= '0;
                    req   <= 1'b1;
                end else begin
                    count <= next_count[CNT_W-1:0];
                end
            end
        end
    end

endmodule

// File: rtl/trig_delay_shaper.sv
// Top of the programmable trigger delay and shaper. It detects trigger edges,
// accepts them only while both branches are idle, starts two delayed pulse
// branches and drives the second-level event counter.
// Assumes: the 200 MHz clock (four cycles per 20 ns delay step) and the
// settings word layout given by the field offsets below.
module trig_delay_shaper #(
    parameter int DLY_W       = 5,
    parameter int WCODE_W     = 4,
    parameter int CNT_W       = 8,
    parameter int TICKS       = 4,
    parameter int W_BASE      = 21,
    parameter int W_KNEE      = 7,
    parameter int SYNC_STAGES = 2,
    parameter int OFS_DLY_A   = 17,
    parameter int OFS_DLY_B   = 12,
    parameter int OFS_WID     = 28,
    parameter int OFS_CNT     = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        trig_in,
    input  logic [31:0] cfg_word,
    output logic        out_a,
    output logic        out_b,
    output logic        l2_req
);

    localparam int NUM_BR = 2;

    logic              rise_w;
    logic              accept_w;
    logic              busy_w;
    logic [NUM_BR-1:0] br_pulse;
    logic [NUM_BR-1:0] br_active;
    logic [WCODE_W-1:0] wid_code;
    logic [CNT_W-1:0]   thresh;

    trig_edge_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (trig_in),
        .rise     (rise_w)
    );

    // Accept an edge only when every branch is idle
    always_comb begin
        busy_w   = |br_active;
        accept_w = rise_w & ~busy_w;
        wid_code = cfg_word[OFS_WID +: WCODE_W];
        thresh   = cfg_word[OFS_CNT +: CNT_W];
    end

    // One branch per output, each reading its own delay field
    for (genvar gi = 0; gi < NUM_BR; gi++) begin : g_br
        localparam int OFS = (gi == 0) ? OFS_DLY_A : OFS_DLY_B;
        trig_branch #(
            .DLY_W   (DLY_W),
            .WCODE_W (WCODE_W),
            .TICKS   (TICKS),
            .W_BASE  (W_BASE),
            .W_KNEE  (W_KNEE)
        ) u_br (
            .clk      (clk),
            .rst_n    (rst_n),
            .start    (accept_w),
            .dly_code (cfg_word[OFS +: DLY_W]),
            .wid_code (wid_code),
            .pulse    (br_pulse[gi]),
            .active   (br_active[gi])
        );
    end

    l1_event_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (accept_w),
        .thresh (thresh),
        .req    (l2_req)
    );

    // Route branch pulses to the named outputs
    always_comb begin
        out_a = br_pulse[0];
        out_b = br_pulse[1];
    end

endmodule

// File: rtl/trig_delay_shaper_chk.sv
// Temporal checks for the trigger delay and shaper, attached by bind.
module trig_delay_shaper_chk (
    input logic clk,
    input logic rst_n,
    input logic trig_in,
    input logic out_a,
    input logic out_b,
    input logic l2_req,
    input logic accept,
    input logic busy
);

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_a && !out_b && !l2_req));

    // R2
    accept_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> $past(trig_in, 2));

    // R4
    min_width_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_a) |=> out_a);

    // R4
    min_width_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_b) |=> out_b);

    // R6
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);

    // R8
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        l2_req |=> !l2_req);

    // R8
    req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        l2_req |-> $past(accept));

endmodule

bind trig_delay_shaper trig_delay_shaper_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_in (trig_in),
    .out_a   (out_a),
    .out_b   (out_b),
    .l2_req  (l2_req),
    .accept  (accept_w),
    .busy    (busy_w)
);

// File: tb/tb_trig_delay_shaper.sv
module tb_trig_delay_shaper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_in = 1'b0;
    logic [31:0] cfg_word = '0;
    logic        out_a, out_b, l2_req;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    trig_delay_shaper dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_in  (trig_in),
        .cfg_word (cfg_word),
        .out_a    (out_a),
        .out_b    (out_b),
        .l2_req   (l2_req)
    );

    // ---------------- behavioural reference ----------------
    bit h1, h2, h3;           // trig_in samples 1, 2, 3 edges ago
    int cyc;
    int busy_end;
    int sa, ea, sb, eb;
    int evcnt;
    bit exp_a, exp_b, exp_l2;

    function automatic int wlen(int w);
        return (w < 7) ? 21 + w : w;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            h1 = 0; h2 = 0; h3 = 0;
            cyc = 0; busy_end = 0; evcnt = 0;
            sa = -100; ea = -100; sb = -100; eb = -100;
            exp_a = 0; exp_b = 0; exp_l2 = 0;
        end else begin
            bit rise;
            int n;
            rise = h2 && !h3;
            exp_l2 = 0;
            if (rise && cyc >= busy_end) begin
                sa = cyc + 4 * int'(cfg_word[21:17]);
                sb = cyc + 4 * int'(cfg_word[16:12]);
                ea = sa + wlen(int'(cfg_word[31:28]));
                eb = sb + wlen(int'(cfg_word[31:28]));
                busy_end = (ea > eb) ? ea : eb;
                n = int'(cfg_word[7:0]);
                if (n == 0) evcnt = 0;
                else if (evcnt + 1 >= n) begin evcnt = 0; exp_l2 = 1; end
                else evcnt = evcnt + 1;
            end
            exp_a = (cyc >= sa) && (cyc < ea);
            exp_b = (cyc >= sb) && (cyc < eb);
            h3 = h2; h2 = h1; h1 = trig_in;
            cyc = cyc + 1;
        end
    end

    // Compare on every falling edge once the bench is running
    always @(negedge clk) begin
        if (!done && cyc > 0) begin
            checks++;
            if (out_a !== exp_a || out_b !== exp_b || l2_req !== exp_l2) begin
                errors++;
                $display("FAIL %s cyc %0d: a/b/l2 actual %b%b%b expected %b%b%b",
                         cur_req, cyc, out_a, out_b, l2_req, exp_a, exp_b, exp_l2);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic fire(int high);
        @(negedge clk); trig_in = 1'b1;
        idle(high);
        trig_in = 1'b0;
    endtask

    function automatic logic [31:0] mk(int w, int da, int db, int n);
        logic [31:0] v = '0;
        v[31:28] = 4'(w);
        v[21:17] = 5'(da);
        v[16:12] = 5'(db);
        v[7:0]   = 8'(n);
        return v;
    endfunction

    initial begin
        // R1: reset state
        idle(3);
        checks++;
        if (out_a !== 1'b0 || out_b !== 1'b0 || l2_req !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: a/b/l2 actual %b%b%b expected 000", out_a, out_b, l2_req);
        end
        rst_n = 1'b1;

        cur_req = "R2";
        cfg_word = mk(0, 0, 0, 0);
        fire(2); idle(40);

        cur_req = "R3";
        cfg_word = mk(3, 2, 5, 0);
        fire(1); idle(60);
        cfg_word = mk(7, 31, 0, 0);
        fire(1); idle(150);
        cfg_word = mk(7, 0, 31, 0);
        fire(1); idle(150);

        cur_req = "R4";
        cfg_word = mk(6, 1, 0, 0);  fire(1); idle(50);
        cfg_word = mk(7, 1, 0, 0);  fire(1); idle(30);
        cfg_word = mk(15, 0, 1, 0); fire(1); idle(40);

        cur_req = "R5";
        cfg_word = mk(8, 0, 0, 0);
        fire(100); idle(20);

        cur_req = "R6";
        cfg_word = mk(2, 4, 1, 2);
        fire(1); idle(5); fire(1); idle(10); fire(1); idle(60);
        fire(1); idle(60);

        cur_req = "R7";
        cfg_word = mk(5, 3, 2, 0);
        fire(1); idle(8);
        cfg_word = mk(12, 9, 0, 0);
        idle(60);

        cur_req = "R8";
        cfg_word = mk(9, 0, 0, 0);
        for (int k = 0; k < 3; k++) begin fire(1); idle(20); end
        cfg_word = mk(9, 0, 0, 3);
        for (int k = 0; k < 7; k++) begin fire(1); idle(20); end
        cfg_word = mk(9, 0, 0, 5);
        for (int k = 0; k < 3; k++) begin fire(1); idle(20); end
        cfg_word = mk(9, 0, 0, 1);
        fire(1); idle(20);
        fire(1); idle(20);

        cur_req = "R9";
        cfg_word = mk(7, 0, 1, 2);
        for (int k = 0; k < 60; k++) begin
            @(negedge clk); trig_in = ~trig_in;
        end
        trig_in = 1'b0;
        idle(30);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #500000;
        done = 1'b1;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule